// File: doc/BRIEF.md
# External Interrupt Pin Conditioner

This block turns four asynchronous external interrupt pins into four sticky request flags for an interrupt controller. Each pin is brought into the clock domain by a two-flop synchronizer. A per-channel detect-mode field then chooses which condition sets the flag: a rising edge, a falling edge, both edges, a high level or a low level. The two lower channels accept the single-edge and level conditions. The two upper channels accept the single-edge and both-edge conditions. A field value that a channel does not accept turns that channel off.

Channel 3 also passes through a sampled noise filter before detection. A shared prescaler produces a sample tick on every cycle, every 32nd cycle or every 128th cycle. The filter is a four-state machine: `F_LO` (stable low), `F_RISE` (one high sample seen), `F_HI` (stable high) and `F_FALL` (one low sample seen). On a tick with a differing sample, `F_LO` goes to `F_RISE` and `F_HI` goes to `F_FALL`. On a tick that confirms the change, `F_RISE` goes to `F_HI` and `F_FALL` goes to `F_LO`. On a tick that contradicts it, `F_RISE` returns to `F_LO` and `F_FALL` returns to `F_HI`. The filtered level is high in `F_HI` and `F_FALL`, and it drives `filt_o` so that it can feed a timer event input.

Each channel's flag is a two-state machine, `FLAG_IDLE` and `FLAG_SET`. A detected event moves it to `FLAG_SET` or keeps it there. A clear strobe with no event in the same cycle moves it back to `FLAG_IDLE`.

Top module: `xint_cond`

## Requirements
- R1: While reset is low and in the first cycle after it, all of `req_o` and `filt_o` are 0.
- R2: On channels 0 to 2 a pin change is seen at the second clock edge and acts on the flag at the third clock edge. A pulse of a single cycle is therefore accepted.
- R3: On channels 0 and 1, mode 1 detects a rising edge, mode 2 a falling edge, mode 4 a high level and mode 5 a low level.
- R4: On channels 2 and 3, mode 1 detects a rising edge, mode 2 a falling edge and mode 3 both edges.
- R5: Mode 0 and every mode a channel does not accept (3, 6 and 7 on channels 0 and 1; 4 to 7 on channels 2 and 3) leave that channel's flag unset whatever its pin does.
- R6: A level-mode flag stays set through a clear strobe while the level holds. It falls on the first strobe after the level ends.
- R7: A flag changes from 1 to 0 only on a clear strobe. An edge-mode flag stays set when an edge is detected in the same cycle as the strobe.
- R8: `ratio_i` = 0 samples channel 3 on every cycle, 1 on every 32nd cycle and 2 or 3 on every 128th cycle. The sample cycles are counted from reset.
- R9: The filtered level changes only after two consecutive samples agree on the new value. A channel 3 pulse lasting at least 2, 64 or 256 cycles (for ratio 1/1, 1/32 and 1/128) is accepted. A pulse shorter than one sample period is rejected.
- R10: Channel 3 detects its edges on the filtered level. `filt_o` carries that level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Cycle clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | 4 | Raw external interrupt pins |
| mode_i | input | 12 | Detect-mode fields, 3 bits per channel, channel 0 in bits 2:0 |
| ratio_i | input | 2 | Noise-filter sampling ratio select for channel 3 |
| clr_i | input | 4 | Per-channel flag clear strobes |
| req_o | output | 4 | Interrupt request flags |
| filt_o | output | 1 | Filtered channel 3 level |

## Verification
On an unfiltered channel, a pin change reaches the synchronized level after two edges and the flag after three. On channel 3, the filtered level moves at the second agreeing sample tick, and its flag follows one edge after that. A clear strobe acts on the next edge. The bench drives every input on the falling clock edge. Its behavioural model advances at the same rising edge as the design, and the bench compares every flag and the filtered level at the following falling edge. The directed checks wait the exact number of falling edges derived from these latencies, or, for filtered pulses, well beyond two sample periods.

// File: rtl/xint_pkg.sv
package xint_pkg;
    typedef enum logic [2:0] {
        DET_OFF  = 3'd0,
        DET_RISE = 3'd1,
        DET_FALL = 3'd2,
        DET_BOTH = 3'd3,
        DET_HIGH = 3'd4,
        DET_LOW  = 3'd5
    } det_mode_e;

    typedef enum logic [1:0] {
        F_LO   = 2'd0,
        F_RISE = 2'd1,
        F_HI   = 2'd2,
        F_FALL = 2'd3
    } filt_st_e;

    typedef enum logic {
        FLAG_IDLE = 1'b0,
        FLAG_SET  = 1'b1
    } flag_st_e;
endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/xint_prescale.sv
module xint_prescale #(
    parameter int MID_DIV  = 32,
    parameter int SLOW_DIV = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ratio_i,
    output logic       tick_o
);
    localparam int CW = $clog2(SLOW_DIV);
    localparam int MW = $clog2(MID_DIV);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        unique case (ratio_i)
            2'd0:    tick_o = 1'b1;
            2'd1:    tick_o = &cnt_q[MW-1:0];
            default: tick_o = &cnt_q;
        endcase
    end
endmodule

// File: rtl/xint_filter.sv
module xint_filter
    import xint_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic din_i,
    output logic dout_o
);
    filt_st_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= F_LO;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            unique case (st_q)
                F_LO:   st_d = din_i ? F_RISE : F_LO;
                F_RISE: st_d = din_i ? F_HI   : F_LO;
                F_HI:   st_d = din_i ? F_HI   : F_FALL;
                F_FALL: st_d = din_i ? F_HI   : F_LO;
            endcase
        end
    end

    always_comb begin
        unique case (st_q)
            F_HI, F_FALL: dout_o = 1'b1;
            default:      dout_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/xint_detect.sv
module xint_detect
    import xint_pkg::*;
#(
    parameter bit LEVEL_OK = 1'b1,
    parameter bit BOTH_OK  = 1'b0,
    parameter int MW       = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lvl_i,
    input  logic [MW-1:0] mode_i,
    input  logic          clr_i,
    output logic          req_o
);
    logic     prev_q;
    logic     rise, fall, hit;
    flag_st_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl_i;
    end

    assign rise = lvl_i & ~prev_q;
    assign fall = ~lvl_i & prev_q;

    always_comb begin
        hit = 1'b0;
        unique case (mode_i)
            DET_RISE: hit = rise;
            DET_FALL: hit = fall;
            DET_BOTH: hit = BOTH_OK & (rise | fall);
            DET_HIGH: hit = LEVEL_OK & lvl_i;
            DET_LOW:  hit = LEVEL_OK & ~lvl_i;
            default:  hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FLAG_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FLAG_IDLE: if (hit) st_d = FLAG_SET;
            FLAG_SET:  if (clr_i && !hit) st_d = FLAG_IDLE;
        endcase
    end

    always_comb req_o = (st_q == FLAG_SET);
endmodule

// File: rtl/xint_cond.sv
module xint_cond #(
    parameter int NCH        = 4,
    parameter int MW         = 3,
    parameter int LEVEL_CHS  = 2,
    parameter int FILT_CH    = 3,
    parameter int MID_DIV    = 32,
    parameter int SLOW_DIV   = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    pin_i,
    input  logic [NCH*MW-1:0] mode_i,
    input  logic [1:0]        ratio_i,
    input  logic [NCH-1:0]    clr_i,
    output logic [NCH-1:0]    req_o,
    output logic              filt_o
);
    logic [NCH-1:0] sync_q;
    logic           samp_tick;

    xint_sync #(.W(NCH), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (sync_q)
    );

    xint_prescale #(.MID_DIV(MID_DIV), .SLOW_DIV(SLOW_DIV)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .ratio_i (ratio_i),
        .tick_o  (samp_tick)
    );

    xint_filter u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (samp_tick),
        .din_i  (sync_q[FILT_CH]),
        .dout_o (filt_o)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic det_in;
        if (ch == FILT_CH) begin : g_filt
            assign det_in = filt_o;
        end else begin : g_raw
            assign det_in = sync_q[ch];
        end

        xint_detect #(
            .LEVEL_OK (ch < LEVEL_CHS),
            .BOTH_OK  (ch >= LEVEL_CHS),
            .MW       (MW)
        ) u_det (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl_i  (det_in),
            .mode_i (mode_i[ch*MW +: MW]),
            .clr_i  (clr_i[ch]),
            .req_o  (req_o[ch])
        );
    end
endmodule

// File: rtl/xint_chk.sv
module xint_chk #(
    parameter int NCH       = 4,
    parameter int MW        = 3,
    parameter int LEVEL_CHS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NCH*MW-1:0] mode_i,
    input logic [NCH-1:0]    clr_i,
    input logic [NCH-1:0]    req_o,
    input logic              filt_o,
    input logic [NCH-1:0]    sync_q,
    input logic              samp_tick
);
    logic seen_clk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_clk <= 1'b0;
        else        seen_clk <= 1'b1;
    end

    // R1: outputs are clear while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_clear: assert (req_o == '0 && filt_o == 1'b0)
                else $error("R1 outputs not clear in reset");
        end
    end

    // R9: the filtered level moves only on a sample tick
    a_r9_filt_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_clk && !samp_tick) |=> $stable(filt_o));

    for (genvar ch = 0; ch < NCH; ch++) begin : g_a
        logic [MW-1:0] m;
        logic          ok;
        assign m = mode_i[ch*MW +: MW];
        always_comb begin
            if (ch < LEVEL_CHS) ok = (m == 3'd1) || (m == 3'd2) || (m == 3'd4) || (m == 3'd5);
            else                ok = (m == 3'd1) || (m == 3'd2) || (m == 3'd3);
        end

        // R5: an off or unsupported mode never raises the flag
        a_r5_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (seen_clk && !ok && !req_o[ch]) |=> !req_o[ch]);

        // R7: a flag drops only on a clear strobe
        a_r7_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
            (seen_clk && req_o[ch] && !clr_i[ch]) |=> req_o[ch]);

        if (ch < LEVEL_CHS) begin : g_lvl
            // R6: an active level keeps the flag set
            a_r6_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (seen_clk && m == 3'd4 && sync_q[ch]) |=> req_o[ch]);
        end
    end
endmodule

bind xint_cond xint_chk #(.NCH(NCH), .MW(MW), .LEVEL_CHS(LEVEL_CHS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode_i),
    .clr_i     (clr_i),
    .req_o     (req_o),
    .filt_o    (filt_o),
    .sync_q    (sync_q),
    .samp_tick (samp_tick)
);

// File: tb/tb_xint_cond.sv
`timescale 1ns/1ps
module tb_xint_cond;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [3:0]  pin_i = 0;
    logic [11:0] mode_i = 0;
    logic [1:0]  ratio_i = 0;
    logic [3:0]  clr_i = 0;
    logic [3:0]  req_o;
    logic        filt_o;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";
    bit done = 0;

    always #2 clk = ~clk;

    xint_cond dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .mode_i(mode_i),
        .ratio_i(ratio_i), .clr_i(clr_i), .req_o(req_o), .filt_o(filt_o)
    );

    // behavioural reference model
    bit m_s1 [4], m_s2 [4], m_prev [4], m_flag [4];
    bit m_fout;
    int m_pend, m_cnt;

    function automatic bit accepts(int ch, int md);
        if (ch < 2) return md == 1 || md == 2 || md == 4 || md == 5;
        return md >= 1 && md <= 3;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            foreach (m_s1[i]) begin m_s1[i] = 0; m_s2[i] = 0; m_prev[i] = 0; m_flag[i] = 0; end
            m_fout = 0; m_pend = 0; m_cnt = 0;
        end else begin
            int div;
            for (int ch = 0; ch < 4; ch++) begin
                bit now, ev;
                int md;
                now = (ch == 3) ? m_fout : m_s2[ch];
                md  = int'(mode_i[ch*3 +: 3]);
                ev  = 0;
                if (accepts(ch, md)) begin
                    case (md)
                        1: ev = now && !m_prev[ch];
                        2: ev = !now && m_prev[ch];
                        3: ev = now != m_prev[ch];
                        4: ev = now;
                        5: ev = !now;
                        default: ev = 0;
                    endcase
                end
                m_flag[ch] = ev || (m_flag[ch] && !clr_i[ch]);
                m_prev[ch] = now;
            end
            div = (ratio_i == 0) ? 1 : (ratio_i == 1) ? 32 : 128;
            if ((m_cnt % div) == div - 1) begin
                if (m_s2[3] != m_fout) begin
                    m_pend++;
                    if (m_pend == 2) begin m_fout = m_s2[3]; m_pend = 0; end
                end else m_pend = 0;
            end
            m_cnt++;
            foreach (m_s2[i]) begin m_s2[i] = m_s1[i]; m_s1[i] = pin_i[i]; end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int ch = 0; ch < 4; ch++) begin
                checks++;
                if (req_o[ch] !== m_flag[ch]) begin
                    fails++;
                    $display("FAIL %s model ch%0d req actual=%b expected=%b t=%0t", cur_req, ch, req_o[ch], m_flag[ch], $time);
                end
            end
            checks++;
            if (filt_o !== m_fout) begin
                fails++;
                $display("FAIL %s model filt actual=%b expected=%b t=%0t", cur_req, filt_o, m_fout, $time);
            end
        end
    end

    task automatic expect_bit(string r, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b", r, what, act, exp);
        end
    endtask

    task automatic wait_n(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_mode(int ch, int md);
        mode_i[ch*3 +: 3] = 3'(md);
    endtask

    task automatic clear(logic [3:0] mask);
        clr_i = mask; @(negedge clk); clr_i = 0;
    endtask

    task automatic pulse(int ch, int len);
        pin_i[ch] = 1; wait_n(len); pin_i[ch] = 0;
    endtask

    initial begin
        wait_n(3);
        rst_n = 1;
        @(negedge clk);
        expect_bit("R1", "req after reset", req_o[0] | req_o[1] | req_o[2] | req_o[3], 1'b0);
        expect_bit("R1", "filt after reset", filt_o, 1'b0);

        // R2 / R3: channel 0 rising, latency of three edges
        cur_req = "R2";
        set_mode(0, 1); wait_n(2);
        pin_i[0] = 1; wait_n(2);
        expect_bit("R2", "ch0 flag before third edge", req_o[0], 1'b0);
        wait_n(1);
        expect_bit("R2", "ch0 flag at third edge", req_o[0], 1'b1);
        clear(4'b0001); wait_n(1);
        expect_bit("R7", "ch0 flag cleared", req_o[0], 1'b0);

        // R3: channel 0 falling, single-cycle low pulse
        cur_req = "R3";
        set_mode(0, 2); pin_i[0] = 0; wait_n(1); pin_i[0] = 1; wait_n(5);
        expect_bit("R3", "ch0 falling flag", req_o[0], 1'b1);
        clear(4'b0001); pulse(0, 1); wait_n(4);
        clear(4'b0001); wait_n(1);
        set_mode(1, 5); wait_n(3);
        expect_bit("R3", "ch1 low level flag", req_o[1], 1'b1);
        set_mode(1, 0); clear(4'b0010); wait_n(1);
        expect_bit("R3", "ch1 low flag cleared", req_o[1], 1'b0);

        // R6: level flag survives a clear while the level holds
        cur_req = "R6";
        set_mode(1, 4); pin_i[1] = 1; wait_n(4);
        clear(4'b0010); wait_n(1);
        expect_bit("R6", "ch1 held through clear", req_o[1], 1'b1);
        pin_i[1] = 0; wait_n(4);
        clear(4'b0010); wait_n(1);
        expect_bit("R6", "ch1 dropped after level ends", req_o[1], 1'b0);

        // R4 / R7: channel 2 both edges, clear racing an edge
        cur_req = "R4";
        set_mode(2, 3); pulse(2, 3); wait_n(4);
        expect_bit("R4", "ch2 both-edge flag", req_o[2], 1'b1);
        clear(4'b0100); wait_n(1);
        expect_bit("R7", "ch2 cleared", req_o[2], 1'b0);
        cur_req = "R7";
        pin_i[2] = 1; wait_n(2); clr_i[2] = 1; wait_n(1); clr_i[2] = 0;
        expect_bit("R7", "ch2 edge beats clear", req_o[2], 1'b1);
        pin_i[2] = 0; wait_n(4); clear(4'b0100);

        // R5: unsupported modes stay quiet
        cur_req = "R5";
        set_mode(2, 4); pulse(2, 3); wait_n(6);
        expect_bit("R5", "ch2 level mode off", req_o[2], 1'b0);
        set_mode(0, 3); pulse(0, 2); wait_n(6);
        expect_bit("R5", "ch0 both-edge mode off", req_o[0], 1'b0);
        set_mode(1, 7); pulse(1, 2); wait_n(6);
        expect_bit("R5", "ch1 mode 7 off", req_o[1], 1'b0);

        // R8 / R9 / R10: filtered channel 3
        cur_req = "R9";
        set_mode(3, 1); ratio_i = 0; wait_n(4); clear(4'b1000);
        pulse(3, 1); wait_n(8);
        expect_bit("R9", "ch3 1-cycle pulse rejected", req_o[3], 1'b0);
        pulse(3, 2); wait_n(8);
        expect_bit("R10", "ch3 2-cycle pulse accepted", req_o[3], 1'b1);
        clear(4'b1000);
        cur_req = "R8";
        ratio_i = 1; wait_n(2);
        pulse(3, 20); wait_n(150);
        expect_bit("R8", "ch3 short pulse at 1/32 rejected", req_o[3], 1'b0);
        pulse(3, 64); wait_n(20);
        expect_bit("R10", "filt high during long 1/32 pulse", filt_o | req_o[3], 1'b1);
        wait_n(130);
        expect_bit("R8", "ch3 64-cycle pulse accepted", req_o[3], 1'b1);
        clear(4'b1000);
        ratio_i = 2; set_mode(3, 3); wait_n(2);
        pulse(3, 100); wait_n(600);
        expect_bit("R9", "ch3 short pulse at 1/128 rejected", req_o[3], 1'b0);
        pulse(3, 256); wait_n(600);
        expect_bit("R9", "ch3 256-cycle pulse accepted", req_o[3], 1'b1);
        expect_bit("R10", "filt back low", filt_o, 1'b0);

        wait_n(4);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule